// File: doc/BRIEF.md
# Embedded Video Sync Code Inserter

This block sits on the output path of a pixel source. It takes an 8-bit byte stream with a line-valid flag, a frame-valid flag and a field flag. It produces an 8-bit stream for a host that has no separate timing wires. When insertion is on, each line is wrapped in two four-byte timing codes. Each code is three fixed preamble bytes, 0xFF, 0x00, 0x00, followed by a status byte. The start-of-line code goes just ahead of the payload and the end-of-line code just after it. The host finds line and frame boundaries by searching for the preamble. When insertion is off, the same bytes pass through with active-high horizontal and vertical strobes beside them.

Two status-byte formats can be selected. The first packs field, vertical-blanking and position bits with four protection bits. The second picks one of four programmable bytes: frame start, frame end, line start or line end. A guard stage can rewrite payload bytes so that they cannot be mistaken for a preamble, with separate enables for 0xFF and 0x00. In code mode the output lags the input by five clocks, which is four clocks of code delay plus the output register. The source must leave at least 8 idle clocks between lines.

Controller states: IDLE (blanking, waiting for a line) goes to SAV on an accepted rising line-valid. SAV (three more code bytes) goes to ACT after its status byte. ACT (delayed payload) goes to EAV when the delayed line-valid drops. EAV (three more code bytes) returns to IDLE after its status byte. Any state returns to IDLE when insertion is turned off.

Top module: `sync_code_inserter`

## Requirements
- R1: During and right after reset, `out_data` equals `IDLE_BYTE` (default 0x10), and `out_hsync`, `out_vsync` and `out_err` are low.
- R2: In code mode, a line whose first byte is presented in input cycle t produces the following output:
  - 0xFF, 0x00, 0x00 and a status byte in output cycles t+1 to t+4.
  - Payload byte k in cycle t+5+k.
  - 0xFF, 0x00, 0x00 and a status byte in the four cycles right after the last payload byte.
- R3: With format 1 selected (`cfg_fmt2`=0), the status byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, from bit 7 down to bit 0:
  - H is 0 in the leading code and 1 in the trailing code.
  - F is `in_field` at the line's first byte.
  - V is the inverse of `in_fv` at the line's first byte.
- R4: With format 2 selected, the leading status byte is `cfg_fs_byte` for the first accepted line with `in_fv` high after `in_fv` was low, and `cfg_ls_byte` for any other line. The trailing status byte is `cfg_fe_byte` when the line had V=0 and `in_fv` is low in the first cycle after its last byte, and `cfg_le_byte` otherwise.
- R5: When `cfg_clamp_hi` is 1, a 0xFF payload byte is output as 0xFE. When it is 0, the byte passes unchanged.
- R6: When `cfg_clamp_lo` is 1, a 0x00 payload byte is output as 0x01. When it is 0, the byte passes unchanged.
- R7: In code mode, a line that starts with `in_fv` low still gets both codes, with V=1, but each of its payload positions carries `IDLE_BYTE`.
- R8: In code mode, every output cycle not taken by a code or a payload byte carries `IDLE_BYTE`, and `out_hsync` and `out_vsync` stay low.
- R9: With insertion off, output cycle c+1 carries the input of cycle c: the byte (passed through the guard of R5/R6 only while both `in_lv` and `in_fv` are high), `out_hsync`=`in_lv` and `out_vsync`=`in_fv`. No codes are added.
- R10: In code mode, a line whose first byte comes fewer than 8 idle clocks after the previous accepted line's last byte is dropped whole. `out_err` is high for exactly the one output cycle right after that first byte, and the output is as if the line were absent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Incoming pixel byte |
| in_lv | input | 1 | Line-valid, high for each payload byte |
| in_fv | input | 1 | Frame-valid, high across the active lines of a frame |
| in_field | input | 1 | Field flag, sampled at a line's first byte |
| cfg_code_en | input | 1 | 1 = insert codes, 0 = pass-through with strobes |
| cfg_fmt2 | input | 1 | 0 = protected status byte, 1 = programmable status byte |
| cfg_clamp_hi | input | 1 | Rewrite payload 0xFF as 0xFE |
| cfg_clamp_lo | input | 1 | Rewrite payload 0x00 as 0x01 |
| cfg_fs_byte | input | 8 | Format-2 status for frame start |
| cfg_fe_byte | input | 8 | Format-2 status for frame end |
| cfg_ls_byte | input | 8 | Format-2 status for line start |
| cfg_le_byte | input | 8 | Format-2 status for line end |
| out_data | output | 8 | Output byte stream |
| out_hsync | output | 1 | Line strobe in pass-through mode |
| out_vsync | output | 1 | Frame strobe in pass-through mode |
| out_err | output | 1 | One-cycle pulse when a line is dropped for a short gap |

## Verification
The bench targets the following corner cases:

- **Gap of exactly 8 clocks.** A controller that is one cycle late in reaching IDLE would flag this gap and drop the line.
- **Gap of 1 clock.** The new line's bytes enter the delay line while the previous payload is still draining. A design that does not mask the dropped line would run the two lines together or never emit the trailing code.
- **One-byte line.** A design that miscounts the payload window clips it here.
- **Last line of a frame, with frame-valid falling in step with line-valid.** This checks the frame-end selection.
- **First line after frame-valid rises, after a blanking line.** This checks the frame-start selection.
- **Payload bytes of 0xFF and 0x00 under each guard setting.** A swapped enable or a guard applied to code bytes would show up on the output.
- **Blanking lines in both modes.** In code mode these lines carry `IDLE_BYTE`. In pass-through mode they must stay raw.

// File: rtl/sync_code_pkg.sv
package sync_code_pkg;

    // length of one timing reference code in bytes
    localparam int CODE_LEN  = 4;
    // idle clocks the source must leave between lines
    localparam int MIN_GAP   = 2 * CODE_LEN;
    localparam int CNT_W     = $clog2(CODE_LEN);

    localparam logic [7:0] PRE_HI = 8'hFF;
    localparam logic [7:0] PRE_LO = 8'h00;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SAV,
        S_ACT,
        S_EAV
    } ins_state_e;

endpackage

// File: rtl/sci_pipe.sv
module sci_pipe #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (DEPTH == 1) begin : g_single
            logic [W-1:0] stg;
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= din;
            end
            assign dout = stg;
        end else begin : g_chain
            logic [DEPTH-1:0][W-1:0] stg;
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[DEPTH-2:0], din};
            end
            assign dout = stg[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/sci_clamp.sv
module sci_clamp (
    input  logic [7:0] din,
    input  logic       en_hi,
    input  logic       en_lo,
    output logic [7:0] dout
);

    always_comb begin
        dout = din;
        if (en_hi && din == 8'hFF) dout = 8'hFE;
        if (en_lo && din == 8'h00) dout = 8'h01;
    end

endmodule

// File: rtl/sci_status.sv
module sci_status (
    input  logic       fmt2,
    input  logic       f,
    input  logic       v,
    input  logic       h,
    input  logic       edge_flag,
    input  logic [7:0] b_fs,
    input  logic [7:0] b_fe,
    input  logic [7:0] b_ls,
    input  logic [7:0] b_le,
    output logic [7:0] code
);

    logic [7:0] prot;
    logic [7:0] prog;

    always_comb begin
        prot = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        if (h) prog = edge_flag ? b_fe : b_le;
        else   prog = edge_flag ? b_fs : b_ls;
        code = fmt2 ? prog : prot;
    end

endmodule

// File: rtl/sync_code_inserter.sv
module sync_code_inserter
    import sync_code_pkg::*;
#(
    parameter logic [7:0] IDLE_BYTE = 8'h10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_lv,
    input  logic       in_fv,
    input  logic       in_field,
    input  logic       cfg_code_en,
    input  logic       cfg_fmt2,
    input  logic       cfg_clamp_hi,
    input  logic       cfg_clamp_lo,
    input  logic [7:0] cfg_fs_byte,
    input  logic [7:0] cfg_fe_byte,
    input  logic [7:0] cfg_ls_byte,
    input  logic [7:0] cfg_le_byte,
    output logic [7:0] out_data,
    output logic       out_hsync,
    output logic       out_vsync,
    output logic       out_err
);

    localparam int PIPE_W = 10;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CODE_LEN - 1);

    ins_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic lv_q, drop_q;
    logic rise, busy, reject, drop_c, take, start;

    logic        p_take, p_fv;
    logic [7:0]  p_data, p_clamp, b_clamp, stat;

    logic f_q, v_q, fs_q, fe_q, seen_q;

    logic [7:0] nxt_data;
    logic       nxt_hs, nxt_vs, nxt_err;

    // ---------------- line edge detection and gap rule ----------------
    always_comb begin
        rise   = in_lv & ~lv_q;
        busy   = (st_q != S_IDLE);
        reject = cfg_code_en & rise & busy;
        drop_c = reject | (drop_q & in_lv);
        take   = in_lv & ~drop_c;
        start  = cfg_code_en & rise & ~busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lv_q   <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            lv_q   <= in_lv;
            drop_q <= drop_c;
        end
    end

    // ---------------- payload delay covering the leading code ----------------
    sci_pipe #(.W(PIPE_W), .DEPTH(CODE_LEN)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({take, in_fv, in_data}),
        .dout  ({p_take, p_fv, p_data})
    );

    sci_clamp u_clamp_code (
        .din   (p_data),
        .en_hi (cfg_clamp_hi),
        .en_lo (cfg_clamp_lo),
        .dout  (p_clamp)
    );

    sci_clamp u_clamp_pass (
        .din   (in_data),
        .en_hi (cfg_clamp_hi),
        .en_lo (cfg_clamp_lo),
        .dout  (b_clamp)
    );

    // ---------------- per-line status flags ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= 1'b0;
            v_q    <= 1'b0;
            fs_q   <= 1'b0;
            fe_q   <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            if (start) begin
                f_q  <= in_field;
                v_q  <= ~in_fv;
                fs_q <= in_fv & ~seen_q;
            end
            if (st_q == S_ACT && !p_take)
                fe_q <= ~v_q & ~p_fv;
            seen_q <= in_fv ? (seen_q | start) : 1'b0;
        end
    end

    sci_status u_status (
        .fmt2      (cfg_fmt2),
        .f         (f_q),
        .v         (v_q),
        .h         (st_q == S_EAV),
        .edge_flag ((st_q == S_EAV) ? fe_q : fs_q),
        .b_fs      (cfg_fs_byte),
        .b_fe      (cfg_fe_byte),
        .b_ls      (cfg_ls_byte),
        .b_le      (cfg_le_byte),
        .code      (stat)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            S_IDLE: begin
                if (start) begin
                    st_d  = S_SAV;
                    cnt_d = CNT_W'(1);
                end
            end
            S_SAV: begin
                if (cnt_q == LAST_IDX) begin
                    st_d  = S_ACT;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_ACT: begin
                if (!p_take) begin
                    st_d  = S_EAV;
                    cnt_d = CNT_W'(1);
                end
            end
            S_EAV: begin
                if (cnt_q == LAST_IDX) begin
                    st_d  = S_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
        if (!cfg_code_en) begin
            st_d  = S_IDLE;
            cnt_d = '0;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        nxt_data = IDLE_BYTE;
        nxt_hs   = 1'b0;
        nxt_vs   = 1'b0;
        nxt_err  = reject;
        if (!cfg_code_en) begin
            nxt_data = (in_lv && in_fv) ? b_clamp : in_data;
            nxt_hs   = in_lv;
            nxt_vs   = in_fv;
        end else begin
            unique case (st_q)
                S_IDLE:        nxt_data = start ? PRE_HI : IDLE_BYTE;
                S_SAV, S_EAV:  nxt_data = (cnt_q == LAST_IDX) ? stat : PRE_LO;
                S_ACT:         nxt_data = p_take ? (v_q ? IDLE_BYTE : p_clamp) : PRE_HI;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= IDLE_BYTE;
            out_hsync <= 1'b0;
            out_vsync <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_data  <= nxt_data;
            out_hsync <= nxt_hs;
            out_vsync <= nxt_vs;
            out_err   <= nxt_err;
        end
    end

    // ---------------- assertions ----------------
    p_err_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> $past(st_q != S_IDLE))
        else $error("drop flagged while controller was idle");

    p_code_opens_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == S_SAV || st_q == S_EAV) && cnt_q == CNT_W'(1) && cfg_code_en)
            |-> out_data == PRE_HI)
        else $error("code did not open with 0xFF");

    p_fmt1_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ACT && $past(st_q) == S_SAV && !$past(cfg_fmt2) && $past(cfg_code_en))
            |-> out_data[7])
        else $error("format-1 status byte missing its top bit");

    p_no_ff_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_code_en && st_q == S_ACT && p_take && cfg_clamp_hi) |=> out_data != PRE_HI)
        else $error("guarded payload produced 0xFF");

    p_quiet_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_code_en) |-> (!out_hsync && !out_vsync))
        else $error("strobe active in code mode");

endmodule

// File: tb/sim_sync_code_inserter.sv
module sim_sync_code_inserter;

    localparam int         CLK_NS = 10;
    localparam logic [7:0] IDLE   = 8'h10;
    localparam int         HN     = 4096;

    logic       clk, rst_n;
    logic [7:0] in_data;
    logic       in_lv, in_fv, in_field;
    logic       cfg_code_en, cfg_fmt2, cfg_clamp_hi, cfg_clamp_lo;
    logic [7:0] cfg_fs_byte, cfg_fe_byte, cfg_ls_byte, cfg_le_byte;
    logic [7:0] out_data;
    logic       out_hsync, out_vsync, out_err;

    sync_code_inserter #(.IDLE_BYTE(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_lv(in_lv), .in_fv(in_fv),
        .in_field(in_field), .cfg_code_en(cfg_code_en), .cfg_fmt2(cfg_fmt2),
        .cfg_clamp_hi(cfg_clamp_hi), .cfg_clamp_lo(cfg_clamp_lo),
        .cfg_fs_byte(cfg_fs_byte), .cfg_fe_byte(cfg_fe_byte),
        .cfg_ls_byte(cfg_ls_byte), .cfg_le_byte(cfg_le_byte),
        .out_data(out_data), .out_hsync(out_hsync), .out_vsync(out_vsync), .out_err(out_err)
    );

    // expected output per output cycle
    logic [7:0] e_data [HN];
    logic [1:0] e_sync [HN];
    logic       e_err  [HN];
    string      e_tag  [HN];
    string      e_stag [HN];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // wanted configuration, applied at the next drive
    bit       w_code = 1, w_fmt2 = 0, w_hi = 1, w_lo = 1;
    bit [7:0] w_fs = 8'hA1, w_fe = 8'hB2, w_ls = 8'hC3, w_le = 8'hD4;

    // reference model state
    bit m_plv = 0, m_acc = 0, m_seen = 0, m_f = 0, m_v = 0, m_fs = 0;
    int m_free = 0;

    initial begin
        clk = 1'b0;
        forever #(CLK_NS / 2) clk = ~clk;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        summary();
        $finish;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got %h expected %h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [7:0] guard(input logic [7:0] d);
        if (w_hi && d == 8'hFF) return 8'hFE;
        if (w_lo && d == 8'h00) return 8'h01;
        return d;
    endfunction

    function automatic string gtag(input logic [7:0] d, input string dflt);
        if (d == 8'hFF) return "R5";
        if (d == 8'h00) return "R6";
        return dflt;
    endfunction

    function automatic logic [7:0] status(input bit h, input bit edge_f);
        if (w_fmt2) begin
            if (h) return edge_f ? w_fe : w_le;
            return edge_f ? w_fs : w_ls;
        end
        return {1'b1, m_f, m_v, h, m_v ^ h, m_f ^ h, m_f ^ m_v, m_f ^ m_v ^ h};
    endfunction

    task automatic put_code(input int at, input bit h, input bit edge_f);
        e_data[at]   = 8'hFF; e_tag[at]   = "R2";
        e_data[at+1] = 8'h00; e_tag[at+1] = "R2";
        e_data[at+2] = 8'h00; e_tag[at+2] = "R2";
        e_data[at+3] = status(h, edge_f);
        e_tag[at+3]  = w_fmt2 ? "R4" : "R3";
    endtask

    task automatic model(input bit lv, input bit fv, input bit fld, input logic [7:0] d);
        bit rise;
        rise = lv && !m_plv;
        if (!w_code) begin
            e_data[cyc+1] = (lv && fv) ? guard(d) : d;
            e_tag[cyc+1]  = (lv && fv) ? gtag(d, "R9") : "R9";
            e_sync[cyc+1] = {lv, fv};
            e_stag[cyc+1] = "R9";
            m_acc = 0;
        end else begin
            if (rise) begin
                if (cyc >= m_free) begin
                    m_acc = 1;
                    m_fs  = fv && !m_seen;
                    m_f   = fld;
                    m_v   = !fv;
                    put_code(cyc + 1, 1'b0, m_fs);
                end else begin
                    e_err[cyc+1] = 1'b1;   // R10 dropped line
                end
            end
            if (lv && m_acc) begin
                if (m_v) begin
                    e_data[cyc+5] = IDLE; e_tag[cyc+5] = "R7";
                end else begin
                    e_data[cyc+5] = guard(d); e_tag[cyc+5] = gtag(d, "R2");
                end
            end
            if (!lv && m_plv && m_acc) begin
                put_code(cyc + 5, 1'b1, !m_v && !fv);
                m_free = cyc + 8;
                m_acc  = 0;
            end
        end
        if (!fv) m_seen = 0;
        else if (rise && m_acc && w_code) m_seen = 1;
        m_plv = lv;
    endtask

    task automatic tick(input bit lv, input bit fv, input bit fld, input logic [7:0] d);
        @(negedge clk);
        check(e_tag[cyc], out_data, e_data[cyc]);
        check(e_stag[cyc], {6'd0, out_hsync, out_vsync}, {6'd0, e_sync[cyc]});
        check("R10", {7'd0, out_err}, {7'd0, e_err[cyc]});
        cfg_code_en = w_code; cfg_fmt2 = w_fmt2;
        cfg_clamp_hi = w_hi;  cfg_clamp_lo = w_lo;
        cfg_fs_byte = w_fs; cfg_fe_byte = w_fe; cfg_ls_byte = w_ls; cfg_le_byte = w_le;
        in_lv = lv; in_fv = fv; in_field = fld; in_data = d;
        model(lv, fv, fld, d);
        cyc++;
    endtask

    task automatic idle(input int n, input bit fv);
        for (int i = 0; i < n; i++) tick(1'b0, fv, 1'b0, 8'h00);
    endtask

    task automatic line(input bit fv, input bit fld, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            if (i == 1)      d = 8'hFF;
            else if (i == 2) d = 8'h00;
            else             d = 8'(seed + i * 29 + 7);
            tick(1'b1, fv, fld, d);
        end
    endtask

    initial begin
        for (int i = 0; i < HN; i++) begin
            e_data[i] = IDLE; e_sync[i] = 2'b00; e_err[i] = 1'b0;
            e_tag[i] = "R8";  e_stag[i] = "R8";
        end
        rst_n = 1'b0;
        in_lv = 0; in_fv = 0; in_field = 0; in_data = 8'h00;
        cfg_code_en = w_code; cfg_fmt2 = w_fmt2; cfg_clamp_hi = w_hi; cfg_clamp_lo = w_lo;
        cfg_fs_byte = w_fs; cfg_fe_byte = w_fe; cfg_ls_byte = w_ls; cfg_le_byte = w_le;
        repeat (3) @(negedge clk);
        check("R1", out_data, IDLE);
        check("R1", {5'd0, out_hsync, out_vsync, out_err}, 8'd0);
        rst_n = 1'b1;

        // format 1, both guards on
        idle(6, 0);
        line(0, 0, 4, 3);          // blanking line, R7
        idle(10, 0);
        idle(2, 1);
        line(1, 0, 6, 5);          // frame start
        idle(8, 1);                // exactly the minimum gap
        line(1, 0, 5, 9);
        idle(3, 1);                // too short: R10
        line(1, 0, 5, 11);
        idle(12, 1);
        line(1, 0, 1, 40);         // one-byte line
        idle(8, 1);
        line(1, 0, 7, 13);         // frame end
        idle(20, 0);
        idle(2, 1);
        line(1, 1, 4, 17);         // second field
        idle(9, 1);
        line(1, 1, 3, 19);
        idle(15, 0);

        // format 2, guards off
        w_fmt2 = 1; w_hi = 0; w_lo = 0;
        idle(2, 0);
        idle(2, 1);
        line(1, 0, 5, 21);
        idle(8, 1);
        line(1, 0, 4, 23);
        idle(12, 0);
        line(0, 0, 3, 25);
        idle(12, 0);

        // pass-through, only high guard
        w_code = 0; w_hi = 1; w_lo = 0;
        idle(3, 0);
        idle(2, 1);
        line(1, 0, 5, 27);
        idle(2, 1);
        line(1, 0, 3, 29);
        idle(3, 0);
        line(0, 0, 3, 31);
        idle(4, 0);

        // back to format 1, only low guard, gap of one
        w_code = 1; w_fmt2 = 0; w_hi = 0; w_lo = 1;
        idle(4, 0);
        idle(1, 1);
        line(1, 0, 4, 33);
        idle(1, 1);
        line(1, 0, 3, 35);
        idle(12, 0);
        idle(10, 0);

        summary();
        $finish;
    end

endmodule